// File: doc/BRIEF.md
# SPI Master Slave-Select Controller

This block sits beside the shift engine of an SPI master and owns the slave-select lines. A two-bit select mask chooses which attached device is addressed. In manual mode the chosen line follows the mask directly, so software holds the device selected across several words. In automatic mode the chosen line is asserted only while a word is being shifted and is released as soon as the engine reports the word complete. A level control sets whether "selected" means a low or a high pin.

The block also paces back-to-back words. When the engine reports a word done, a suspend timer is loaded with (13 + 2·N) half-periods of the serial clock, where N is a 4-bit gap setting. This gives a minimum gap of (6.5 + N) serial-clock periods. The engine may begin a new word only while the start-permit output is high. That output is low from the start of a word, through its end, and until the suspend timer has counted its half-period ticks down to zero.

Top module: `spi_ss_ctrl`

## Requirements
- R1: At most one select line is asserted at a time. When both mask bits are set, only line 0 (mask bit 0) is asserted.
- R2: In manual mode (`auto_mode`=0), the asserted line equals the decoded mask from the cycle after the mask is sampled. Transfer handshakes have no effect on it.
- R3: In automatic mode (`auto_mode`=1), the decoded line is asserted from the cycle after `xfer_start` is sampled. It stays asserted until the cycle after `xfer_done` is sampled, when it is released. Outside a transfer no line is asserted.
- R4: With `act_high`=0 an asserted line drives 0 and an idle line drives 1. With `act_high`=1 the levels are reversed. A change of `act_high` reaches the pins in the same cycle.
- R5: After reset, and whenever the mask is 00, both lines sit at their inactive level. After reset `start_ok` is 1.
- R6: After `xfer_done` is sampled, `start_ok` stays 0 until (13 + 2·`gap_cfg`) `half_tick` pulses have been sampled. It rises in the cycle after the edge that samples the last of them.
- R7: `start_ok` is 0 from the cycle after `xfer_start` is sampled until the suspend gap that follows the matching `xfer_done` has expired.
- R8: A `half_tick` sampled in the same cycle as `xfer_done` does not count toward the gap.
- R9: `gap_cfg` is captured when `xfer_done` is sampled. Changing it during a running gap does not change that gap's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_mask | input | 2 | Device select mask; bit i addresses line i |
| auto_mode | input | 1 | 0: manual select, 1: select per transfer |
| act_high | input | 1 | 0: lines active low, 1: lines active high |
| gap_cfg | input | 4 | Extra suspend gap in whole serial-clock periods |
| xfer_start | input | 1 | One-cycle pulse from the shift engine: a word begins |
| xfer_done | input | 1 | One-cycle pulse from the shift engine: a word has ended |
| half_tick | input | 1 | One-cycle pulse per serial-clock half period |
| ss_out | output | 2 | Slave-select pins |
| start_ok | output | 1 | High when the engine may begin a new word |

## Verification
The bench counts the gap exactly at both ends of the range, gap 0 (13 ticks) and gap 15 (43 ticks). An off-by-one timer would raise `start_ok` one tick early or late, and a timer that ignored the gap setting would produce the wrong length. It places a tick in the same cycle as `xfer_done`, so a design that counted that tick would permit the next word one half period too early. It changes `gap_cfg` in the middle of a gap, which would stretch the wait in a design that reads the setting live. It also sets both mask bits in each mode and flips the level mid-run, so a design that drove two devices or latched the polarity late would show the wrong pin values.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;

    typedef enum logic {
        SEL_MANUAL = 1'b0,
        SEL_AUTO   = 1'b1
    } sel_mode_e;

    // half-periods of the fixed part of the suspend gap (6.5 periods)
    localparam int unsigned GAP_BASE_HALVES = 13;

endpackage

// File: rtl/spi_ss_pick.sv
module spi_ss_pick #(
    parameter int unsigned NUM_SS = 2
) (
    input  logic [NUM_SS-1:0] mask,
    output logic [NUM_SS-1:0] pick
);

    // seen[i]: some lower-numbered line is requested
    logic [NUM_SS-1:0] seen;

    for (genvar i = 0; i < NUM_SS; i++) begin : g_line
        if (i == 0) begin : g_first
            assign seen[i] = 1'b0;
        end else begin : g_rest
            assign seen[i] = seen[i-1] | mask[i-1];
        end
        assign pick[i] = mask[i] & ~seen[i];
    end

endmodule

// File: rtl/spi_ss_gap_timer.sv
module spi_ss_gap_timer #(
    parameter int unsigned GAP_W      = 4,
    parameter int unsigned BASE_HALVES = spi_ss_pkg::GAP_BASE_HALVES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_done,
    input  logic             half_tick,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             busy,
    output logic             start_ok
);

    localparam int unsigned MAX_HALVES = BASE_HALVES + 2 * ((1 << GAP_W) - 1);
    localparam int unsigned CNT_W      = $clog2(MAX_HALVES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } gap_state_t;

    gap_state_t st_d, st_q;
    logic [CNT_W-1:0] load_len;

    always_comb begin
        load_len = CNT_W'(BASE_HALVES) + (CNT_W'(gap_cfg) << 1);
        st_d = st_q;
        if (xfer_done) begin
            st_d.busy = 1'b0;
        end else if (xfer_start) begin
            st_d.busy = 1'b1;
        end
        if (xfer_done) begin
            st_d.cnt = load_len;
        end else if (half_tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign start_ok = ~st_q.busy & (st_q.cnt == '0);

    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !start_ok); // R6
    AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !start_ok); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_HALVES)); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done && !half_tick && !xfer_start) |=> $stable(start_ok)); // R8

endmodule

// File: rtl/spi_ss_level_out.sv
module spi_ss_level_out #(
    parameter int unsigned NUM_SS = 2
) (
    input  logic [NUM_SS-1:0] asr,
    input  logic              act_high,
    output logic [NUM_SS-1:0] ss_out
);

    for (genvar i = 0; i < NUM_SS; i++) begin : g_pin
        assign ss_out[i] = act_high ? asr[i] : ~asr[i];
    end

endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl #(
    parameter int unsigned NUM_SS = 2,
    parameter int unsigned GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SS-1:0] sel_mask,
    input  logic              auto_mode,
    input  logic              act_high,
    input  logic [GAP_W-1:0]  gap_cfg,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic              half_tick,
    output logic [NUM_SS-1:0] ss_out,
    output logic              start_ok
);

    import spi_ss_pkg::*;

    typedef struct packed {
        logic [NUM_SS-1:0] asr;
    } line_state_t;

    line_state_t       ln_d, ln_q;
    logic [NUM_SS-1:0] pick;
    logic              busy;
    sel_mode_e         mode;

    assign mode = sel_mode_e'(auto_mode);

    spi_ss_pick #(.NUM_SS(NUM_SS)) u_pick (
        .mask (sel_mask),
        .pick (pick)
    );

    spi_ss_gap_timer #(
        .GAP_W       (GAP_W),
        .BASE_HALVES (GAP_BASE_HALVES)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_done  (xfer_done),
        .half_tick  (half_tick),
        .gap_cfg    (gap_cfg),
        .busy       (busy),
        .start_ok   (start_ok)
    );

    always_comb begin
        ln_d = ln_q;
        unique case (mode)
            SEL_MANUAL: ln_d.asr = pick;
            SEL_AUTO:   ln_d.asr = ((xfer_start | busy) & ~xfer_done) ? pick : '0;
            default:    ln_d.asr = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    spi_ss_level_out #(.NUM_SS(NUM_SS)) u_lvl (
        .asr      (ln_q.asr),
        .act_high (act_high),
        .ss_out   (ss_out)
    );

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ln_q.asr)); // R1
    AST_MANUAL_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && sel_mask[0]) |=> ln_q.asr[0]); // R2
    AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && xfer_done) |=> (ln_q.asr == '0)); // R3
    AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !busy && !xfer_start) |=> (ln_q.asr == '0)); // R3
    AST_NO_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mask == '0) |=> (ln_q.asr == '0)); // R5

endmodule

// File: tb/spi_ss_ctrl_tb.sv
module spi_ss_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_mask = 2'b00;
    logic       auto_mode = 1'b0;
    logic       act_high = 1'b0;
    logic [3:0] gap_cfg = 4'd0;
    logic       xfer_start = 1'b0;
    logic       xfer_done = 1'b0;
    logic       half_tick = 1'b0;
    logic [1:0] ss_out;
    logic       start_ok;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    logic       m_busy = 1'b0;
    logic [5:0] m_cnt = '0;
    logic [1:0] m_asr = '0;

    always #4 clk = ~clk;

    spi_ss_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sel_mask(sel_mask), .auto_mode(auto_mode),
        .act_high(act_high), .gap_cfg(gap_cfg), .xfer_start(xfer_start),
        .xfer_done(xfer_done), .half_tick(half_tick), .ss_out(ss_out),
        .start_ok(start_ok)
    );

    function automatic logic [1:0] f_pick(input logic [1:0] m);
        return m[0] ? 2'b01 : (m[1] ? 2'b10 : 2'b00);
    endfunction

    function automatic logic [1:0] f_pins(input logic [1:0] a, input logic hi);
        return hi ? a : ~a;
    endfunction

    function automatic logic [5:0] f_len(input logic [3:0] g);
        return 6'd13 + {1'b0, g, 1'b0};
    endfunction

    function automatic logic f_ok();
        return !m_busy && (m_cnt == 6'd0);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [1:0] p;
        p = f_pick(sel_mask);
        if (auto_mode) m_asr = ((xfer_start | m_busy) & ~xfer_done) ? p : 2'b00;
        else           m_asr = p;
        if (xfer_done)       m_busy = 1'b0;
        else if (xfer_start) m_busy = 1'b1;
        if (xfer_done)                       m_cnt = f_len(gap_cfg);
        else if (half_tick && m_cnt != 6'd0) m_cnt = m_cnt - 6'd1;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        xfer_start = 1'b1; cyc(); xfer_start = 1'b0;
    endtask

    task automatic pulse_done(input logic with_tick);
        xfer_done = 1'b1; half_tick = with_tick; cyc();
        xfer_done = 1'b0; half_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        half_tick = 1'b1;
        for (int i = 0; i < n; i++) cyc();
        half_tick = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R5 ss in reset", {6'd0, ss_out}, 8'h03);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 ss after reset", {6'd0, ss_out}, 8'h03);
        chk("R5 start_ok after reset", {7'd0, start_ok}, 8'h01);

        // manual mode
        sel_mask = 2'b11; act_high = 1'b1; cyc();
        chk("R1 both bits -> line0", {6'd0, ss_out}, 8'h01);
        chk("R2 manual immediate", {6'd0, ss_out}, 8'h01);
        sel_mask = 2'b10; act_high = 1'b0; cyc();
        chk("R4 active low line1", {6'd0, ss_out}, 8'h01);
        act_high = 1'b1; #1;
        chk("R4 level flips same cycle", {6'd0, ss_out}, 8'h02);
        @(negedge clk);
        pulse_start(); cyc(); pulse_done(1'b0);
        chk("R2 manual ignores done", {6'd0, ss_out}, 8'h02);
        ticks(13);
        sel_mask = 2'b00; cyc();
        chk("R5 no mask idle", {6'd0, ss_out}, 8'h00);

        // automatic mode
        auto_mode = 1'b1; sel_mask = 2'b01; gap_cfg = 4'd0; cyc();
        chk("R3 auto idle before start", {6'd0, ss_out}, 8'h00);
        chk("R7 permit idle", {7'd0, start_ok}, 8'h01);
        pulse_start();
        chk("R3 auto asserted", {6'd0, ss_out}, 8'h01);
        chk("R7 permit low busy", {7'd0, start_ok}, 8'h00);
        cyc(); cyc();
        chk("R3 auto held", {6'd0, ss_out}, 8'h01);
        pulse_done(1'b1);
        chk("R3 auto released", {6'd0, ss_out}, 8'h00);
        ticks(12);
        chk("R8 done tick not counted", {7'd0, start_ok}, 8'h00);
        ticks(1);
        chk("R6 gap0 expires at 13", {7'd0, start_ok}, 8'h01);

        // gap 15
        gap_cfg = 4'd15; pulse_start(); pulse_done(1'b0);
        ticks(42);
        chk("R6 gap15 low at 42", {7'd0, start_ok}, 8'h00);
        ticks(1);
        chk("R6 gap15 high at 43", {7'd0, start_ok}, 8'h01);

        // gap changed mid-gap
        gap_cfg = 4'd1; pulse_start(); pulse_done(1'b0);
        gap_cfg = 4'd15;
        ticks(14);
        chk("R9 gap captured low", {7'd0, start_ok}, 8'h00);
        ticks(1);
        chk("R9 gap captured high", {7'd0, start_ok}, 8'h01);

        // both bits in auto
        sel_mask = 2'b11; pulse_start();
        chk("R1 auto both -> line0", {6'd0, ss_out}, 8'h01);
        pulse_done(1'b0); ticks(43);

        // random phase
        for (int k = 0; k < 5000; k++) begin
            if ($urandom % 40 == 0) begin
                sel_mask  = 2'($urandom);
                auto_mode = 1'($urandom);
                act_high  = 1'($urandom);
                gap_cfg   = 4'($urandom);
            end
            half_tick  = 1'($urandom);
            xfer_start = f_ok() && ($urandom % 3 == 0);
            xfer_done  = m_busy && ($urandom % 5 == 0);
            cyc();
            chk("R1/R2/R3/R4 random ss", {6'd0, ss_out}, {6'd0, f_pins(m_asr, act_high)});
            chk("R6/R7 random start_ok", {7'd0, start_ok}, {7'd0, f_ok()});
        end
        xfer_start = 1'b0; xfer_done = 1'b0; half_tick = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule